// File: doc/BRIEF.md
# Baseband Transmit Serializer with Header and Frame CRC Insertion

This block takes parallel words one at a time from an on-chip producer and shifts them out one bit at a time to a baseband processor. The baseband supplies the transmit bit clock; the block samples that clock with its own system clock, changes its data output after each falling edge of the transmit clock, and the baseband latches each bit on the following rising edge. No FIFO sits in the path: the producer holds one word ready and the block takes it at the moment the previous word has been shifted out.

A frame has a header of `hdr_len_i` words, a 16-bit header check, a payload of `pay_len_i` words and a 32-bit frame check. The block computes both checks while the data goes out and splices each one into the stream at its boundary. A frame may only begin when the clear-channel input shows an idle medium at the moment the start is requested. If the next word is missing when it is needed, the frame is abandoned and an underrun flag is raised.

Top module: `txser_top`

## Requirements
- R1: A one-cycle `start_i` while idle and with `cca_idle_i` = 1 raises `tx_rdy_o` on the next clock edge, latches both lengths, and clears `underrun_o`.
- R2: A `start_i` while idle with `cca_idle_i` = 0 produces a one-cycle `blocked_o` pulse on the next edge. `tx_rdy_o` stays 0, no word is taken, and `txd_o` stays 0.
- R3: `txd_o` changes only in response to a falling edge of `txc_i` that has passed through the two-flop synchronizer. The new bit appears at most three system clocks after that falling edge and stays stable until the next falling edge.
- R4: Data words are sent least significant bit first. Each word is consumed in the cycle in which `word_take_o` is 1 (this requires `word_valid_i` = 1). Exactly `hdr_len_i` + `pay_len_i` words are taken per frame, header words first.
- R5: The header check goes out right after the last header bit. It is CRC-16 with polynomial 0x1021 and preset 0xFFFF, computed over the header bits in transmit order (feedback = register MSB xor bit; shift left; xor the polynomial when feedback is 1). It is sent ones-complemented, MSB first. With `hdr_len_i` = 0 it is sixteen 0 bits.
- R6: The frame check goes out right after the last payload bit. It is CRC-32 with polynomial 0x04C11DB7 and preset 0xFFFFFFFF, computed the same way over the payload bits only. It is sent ones-complemented, MSB first. With `pay_len_i` = 0 it is thirty-two 0 bits.
- R7: `tx_rdy_o` falls at the first transmit-clock falling edge after the last frame-check bit, so a frame lasts (`hdr_len_i` + `pay_len_i`)·W + 48 rising edges of `txc_i`.
- R8: If `word_valid_i` = 0 when a word is needed, the frame stops at that falling edge. `underrun_o` is set and held, `tx_rdy_o` drops, and `txd_o` returns to 0.
- R9: A `start_i` during an active frame is ignored, and the frame in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request (one-cycle pulse) |
| hdr_len_i | input | LEN_W | Header length in words |
| pay_len_i | input | LEN_W | Payload length in words |
| cca_idle_i | input | 1 | Clear-channel indication, 1 = medium idle |
| word_i | input | W | Next word from the producer |
| word_valid_i | input | 1 | `word_i` holds a word |
| word_take_o | output | 1 | `word_i` is consumed at this clock edge |
| blocked_o | output | 1 | Start refused because the channel is busy |
| underrun_o | output | 1 | Last frame was abandoned for lack of a word |
| tx_rdy_o | output | 1 | Frame in progress toward the baseband |
| txc_i | input | 1 | Transmit bit clock from the baseband |
| txd_o | output | 1 | Serial transmit data |

## Verification
The bench sweeps every combination of header length 0 to 2 and payload length 0 to 3, and compares each received bit against a stream it builds itself with bit-serial CRCs. A wrong bit order, a misplaced splice point or a CRC that also covers the other segment shows up as a mismatch in a named segment. A mistake in the final falling edge changes the bit count. The empty-segment cases expose a design that skips a check or fails to preset it. The bench also tests three control cases. A start with a busy channel must send nothing. A start during an active frame must not restart it. A withheld word must stop the frame after exactly one word, and the underrun flag must clear on the next accepted start.

// File: rtl/txser_pkg.sv
package txser_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_HDR,
        PH_HCRC,
        PH_PAY,
        PH_FCS
    } phase_e;

    localparam int          HCRC_W    = 16;
    localparam logic [15:0] HCRC_POLY = 16'h1021;
    localparam int          FCS_W     = 32;
    localparam logic [31:0] FCS_POLY  = 32'h04C11DB7;

endpackage

// File: rtl/txs_edge_sync.sv
module txs_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    assign fall_o = q.s3 & ~q.s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/txs_crc_serial.sv
module txs_crc_serial #(
    parameter int          N    = 16,
    parameter logic [N-1:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic step_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic msb_o
);
    logic [N-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[N-1] ^ bit_i;
        if (init_i)
            crc_d = '1;
        else if (step_i)
            crc_d = {crc_q[N-2:0], 1'b0} ^ (fb ? POLY : '0);
        else if (shift_i)
            crc_d = {crc_q[N-2:0], 1'b0};
    end

    assign msb_o = crc_q[N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/txser_top.sv
module txser_top
    import txser_pkg::*;
#(
    parameter int W     = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] hdr_len_i,
    input  logic [LEN_W-1:0] pay_len_i,
    input  logic             cca_idle_i,
    input  logic [W-1:0]     word_i,
    input  logic             word_valid_i,
    output logic             word_take_o,
    output logic             blocked_o,
    output logic             underrun_o,
    output logic             tx_rdy_o,
    input  logic             txc_i,
    output logic             txd_o
);
    localparam int MAXB = (W > FCS_W) ? W : FCS_W;
    localparam int BCW  = $clog2(MAXB);

    typedef struct packed {
        phase_e           phase;
        logic [W-1:0]     shreg;
        logic [BCW-1:0]   bits_left;
        logic [LEN_W-1:0] wcnt;
        logic [LEN_W-1:0] hlen;
        logic [LEN_W-1:0] plen;
        logic             txd;
        logic             rdy;
        logic             underrun;
        logic             blocked;
    } st_t;

    st_t    d, q;
    phase_e nxt;
    logic   txc_fall;
    logic   take;
    logic   dbit;
    logic   h_init, h_step, h_shift, h_msb;
    logic   f_init, f_step, f_shift, f_msb;

    txs_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (txc_i),
        .fall_o  (txc_fall)
    );

    txs_crc_serial #(.N(HCRC_W), .POLY(HCRC_POLY)) u_hcrc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (h_init),
        .step_i  (h_step),
        .shift_i (h_shift),
        .bit_i   (dbit),
        .msb_o   (h_msb)
    );

    txs_crc_serial #(.N(FCS_W), .POLY(FCS_POLY)) u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (f_init),
        .step_i  (f_step),
        .shift_i (f_shift),
        .bit_i   (dbit),
        .msb_o   (f_msb)
    );

    // What follows the element that just finished.
    always_comb begin
        nxt = PH_IDLE;
        case (q.phase)
            PH_ARM:  nxt = (q.hlen != '0)     ? PH_HDR : PH_HCRC;
            PH_HDR:  nxt = (q.wcnt != q.hlen) ? PH_HDR : PH_HCRC;
            PH_HCRC: nxt = (q.plen != '0)     ? PH_PAY : PH_FCS;
            PH_PAY:  nxt = (q.wcnt != q.plen) ? PH_PAY : PH_FCS;
            default: nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        d         = q;
        d.blocked = 1'b0;
        take      = 1'b0;
        dbit      = 1'b0;
        h_init    = 1'b0;
        h_step    = 1'b0;
        h_shift   = 1'b0;
        f_init    = 1'b0;
        f_step    = 1'b0;
        f_shift   = 1'b0;

        if (q.phase == PH_IDLE) begin
            if (start_i) begin
                if (cca_idle_i) begin
                    d.phase     = PH_ARM;
                    d.rdy       = 1'b1;
                    d.underrun  = 1'b0;
                    d.hlen      = hdr_len_i;
                    d.plen      = pay_len_i;
                    d.wcnt      = '0;
                    d.bits_left = '0;
                    h_init      = 1'b1;
                    f_init      = 1'b1;
                end else begin
                    d.blocked = 1'b1;
                end
            end
        end else if (txc_fall) begin
            if (q.bits_left != '0) begin
                d.bits_left = q.bits_left - 1'b1;
                case (q.phase)
                    PH_HDR, PH_PAY: begin
                        dbit    = q.shreg[0];
                        d.txd   = dbit;
                        d.shreg = q.shreg >> 1;
                        h_step  = (q.phase == PH_HDR);
                        f_step  = (q.phase == PH_PAY);
                    end
                    PH_HCRC: begin
                        d.txd   = ~h_msb;
                        h_shift = 1'b1;
                    end
                    default: begin
                        d.txd   = ~f_msb;
                        f_shift = 1'b1;
                    end
                endcase
            end else begin
                d.phase = nxt;
                case (nxt)
                    PH_HDR, PH_PAY: begin
                        if (word_valid_i) begin
                            take        = 1'b1;
                            dbit        = word_i[0];
                            d.txd       = dbit;
                            d.shreg     = word_i >> 1;
                            d.bits_left = BCW'(W - 1);
                            d.wcnt      = (q.phase == nxt) ? q.wcnt + 1'b1 : LEN_W'(1);
                            h_step      = (nxt == PH_HDR);
                            f_step      = (nxt == PH_PAY);
                        end else begin
                            d.phase    = PH_IDLE;
                            d.rdy      = 1'b0;
                            d.txd      = 1'b0;
                            d.underrun = 1'b1;
                        end
                    end
                    PH_HCRC: begin
                        d.txd       = ~h_msb;
                        h_shift     = 1'b1;
                        d.bits_left = BCW'(HCRC_W - 1);
                        d.wcnt      = '0;
                    end
                    PH_FCS: begin
                        d.txd       = ~f_msb;
                        f_shift     = 1'b1;
                        d.bits_left = BCW'(FCS_W - 1);
                    end
                    default: begin
                        d.rdy = 1'b0;
                        d.txd = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign word_take_o = take;
    assign blocked_o   = q.blocked;
    assign underrun_o  = q.underrun;
    assign tx_rdy_o    = q.rdy;
    assign txd_o       = q.txd;
endmodule

// File: rtl/txser_chk.sv
module txser_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cca_idle_i,
    input logic word_valid_i,
    input logic word_take_o,
    input logic blocked_o,
    input logic underrun_o,
    input logic tx_rdy_o,
    input logic txd_o,
    input logic txc_fall
);
    // R1
    rdy_rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rdy_o) |-> $past(start_i && cca_idle_i));

    // R2
    blocked_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_o |-> ($past(start_i && !cca_idle_i) && !tx_rdy_o));

    // R3
    txd_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd_o) |-> $past(txc_fall));

    // R4
    take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_take_o |-> word_valid_i);

    // R8
    underrun_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> ($fell(tx_rdy_o) && !txd_o));

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_rdy_o |-> !txd_o);
endmodule

bind txser_top txser_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cca_idle_i   (cca_idle_i),
    .word_valid_i (word_valid_i),
    .word_take_o  (word_take_o),
    .blocked_o    (blocked_o),
    .underrun_o   (underrun_o),
    .tx_rdy_o     (tx_rdy_o),
    .txd_o        (txd_o),
    .txc_fall     (txc_fall)
);

// File: tb/test_txser_top.sv
module test_txser_top;
    localparam int W     = 8;
    localparam int LEN_W = 8;
    localparam int MAXB  = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] hdr_len_i = '0;
    logic [LEN_W-1:0] pay_len_i = '0;
    logic             cca_idle_i = 1'b1;
    logic [W-1:0]     word_i = '0;
    logic             word_valid_i = 1'b0;
    logic             word_take_o, blocked_o, underrun_o, tx_rdy_o, txd_o;
    logic             txc_i = 1'b1;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    int prod_cnt   = 0;
    int prod_avail = 0;
    int prod_seed  = 0;
    bit pend       = 1'b0;

    bit got [MAXB];
    bit expb[MAXB];
    int ngot;

    always #4 clk = ~clk;

    txser_top #(.W(W), .LEN_W(LEN_W)) i_txser_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .hdr_len_i    (hdr_len_i),
        .pay_len_i    (pay_len_i),
        .cca_idle_i   (cca_idle_i),
        .word_i       (word_i),
        .word_valid_i (word_valid_i),
        .word_take_o  (word_take_o),
        .blocked_o    (blocked_o),
        .underrun_o   (underrun_o),
        .tx_rdy_o     (tx_rdy_o),
        .txc_i        (txc_i),
        .txd_o        (txd_o)
    );

    function automatic logic [W-1:0] wordval(int seed, int k);
        return W'((k * 53 + seed * 29 + 7) & 8'hFF);
    endfunction

    // Producer: one word held, advanced after each take.
    always @(negedge clk) begin
        if (pend) begin
            prod_cnt++;
            pend = 1'b0;
        end
        if (word_take_o) pend = 1'b1;
        word_valid_i = (prod_cnt < prod_avail);
        word_i       = wordval(prod_seed, prod_cnt);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    task automatic clks(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One transmit-clock period: fall, wait, rise and sample.
    task automatic txc_period(output bit rdy, output bit b);
        @(negedge clk);
        txc_i = 1'b0;
        clks(8);
        txc_i = 1'b1;
        rdy = tx_rdy_o;
        b   = txd_o;
        clks(8);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    function automatic logic [15:0] step16(logic [15:0] c, bit b);
        bit fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
    endfunction

    function automatic logic [31:0] step32(logic [31:0] c, bit b);
        bit fb = c[31] ^ b;
        return {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    endfunction

    task automatic run_frame(int h, int p, int seed, bit poke);
        int          n = 0;
        int          dbits;
        int          bad_d = 0, bad_h = 0, bad_f = 0;
        logic [15:0] hc = 16'hFFFF;
        logic [31:0] fc = 32'hFFFFFFFF;
        bit          rdy, b;
        for (int k = 0; k < h; k++)
            for (int i = 0; i < W; i++) begin
                b = wordval(seed, k)[i];
                expb[n++] = b;
                hc = step16(hc, b);
            end
        for (int i = 15; i >= 0; i--) expb[n++] = ~hc[i];
        for (int k = h; k < h + p; k++)
            for (int i = 0; i < W; i++) begin
                b = wordval(seed, k)[i];
                expb[n++] = b;
                fc = step32(fc, b);
            end
        for (int i = 31; i >= 0; i--) expb[n++] = ~fc[i];

        @(negedge clk);
        prod_seed = seed; prod_cnt = 0; prod_avail = h + p; pend = 1'b0;
        hdr_len_i = LEN_W'(h); pay_len_i = LEN_W'(p); cca_idle_i = 1'b1;
        pulse_start();
        chk(tx_rdy_o == 1'b1, "R1", "tx_rdy after start", int'(tx_rdy_o), 1);
        chk(underrun_o == 1'b0, "R1", "underrun cleared", int'(underrun_o), 0);
        ngot = 0;
        for (int t = 0; t < 200; t++) begin
            if (poke && ngot == 20) begin
                hdr_len_i = 8'd5;
                pulse_start();
            end
            txc_period(rdy, b);
            if (!rdy) break;
            got[ngot++] = b;
        end
        // R7: frame length in rising edges
        chk(ngot == n, "R7", "frame bit count", ngot, n);
        dbits = h * W;
        for (int i = 0; i < n && i < ngot; i++) begin
            if (got[i] != expb[i]) begin
                if (i < dbits) bad_d++;
                else if (i < dbits + 16) bad_h++;
                else if (i < dbits + 16 + p * W) bad_d++;
                else bad_f++;
            end
        end
        chk(bad_d == 0, poke ? "R9" : "R4", "data bit mismatches", bad_d, 0);
        chk(bad_h == 0, "R5", "header check bit mismatches", bad_h, 0);
        chk(bad_f == 0, "R6", "frame check bit mismatches", bad_f, 0);
        chk(prod_cnt == h + p, "R4", "words taken", prod_cnt, h + p);
        chk(txd_o == 1'b0 && underrun_o == 1'b0, "R7", "idle after frame",
            int'({txd_o, underrun_o}), 0);
    endtask

    initial begin
        bit rdy, b;
        clks(3);
        chk(tx_rdy_o == 0 && txd_o == 0 && underrun_o == 0 && blocked_o == 0,
            "R1", "reset state", int'({tx_rdy_o, txd_o, underrun_o, blocked_o}), 0);
        rst_n = 1'b1;
        clks(4);

        // R2: busy channel refuses the start
        prod_cnt = 0; prod_avail = 4; prod_seed = 1; pend = 1'b0;
        hdr_len_i = 8'd1; pay_len_i = 8'd1; cca_idle_i = 1'b0;
        pulse_start();
        chk(blocked_o == 1'b1, "R2", "blocked pulse", int'(blocked_o), 1);
        chk(tx_rdy_o == 1'b0, "R2", "no tx_rdy when busy", int'(tx_rdy_o), 0);
        @(negedge clk);
        chk(blocked_o == 1'b0, "R2", "blocked is one cycle", int'(blocked_o), 0);
        for (int t = 0; t < 4; t++) begin
            txc_period(rdy, b);
            chk(rdy == 0 && b == 0, "R2", "nothing sent", int'({rdy, b}), 0);
        end
        chk(prod_cnt == 0, "R2", "no word taken", prod_cnt, 0);

        // R4 R5 R6 R7: sweep of lengths, incl. empty segments
        for (int h = 0; h <= 2; h++)
            for (int p = 0; p <= 3; p++)
                run_frame(h, p, h * 4 + p, (h == 1 && p == 2));

        // R8: producer holds back the second word
        @(negedge clk);
        prod_seed = 9; prod_cnt = 0; prod_avail = 1; pend = 1'b0;
        hdr_len_i = 8'd2; pay_len_i = 8'd1; cca_idle_i = 1'b1;
        pulse_start();
        ngot = 0;
        for (int t = 0; t < 60; t++) begin
            txc_period(rdy, b);
            if (!rdy) break;
            got[ngot++] = b;
        end
        chk(ngot == W, "R8", "bits before underrun", ngot, W);
        chk(underrun_o == 1'b1, "R8", "underrun set", int'(underrun_o), 1);
        chk(tx_rdy_o == 0 && txd_o == 0, "R8", "stopped and quiet",
            int'({tx_rdy_o, txd_o}), 0);
        txc_period(rdy, b);
        chk(underrun_o == 1'b1, "R8", "underrun held", int'(underrun_o), 1);

        // R1: next good frame clears the flag and runs normally
        run_frame(1, 1, 11, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule